// File: doc/BRIEF.md
# Integer-Factor Upsampler With Selectable Zero Fill Or Hold

This block multiplies the sample rate of a data stream by a fixed integer factor FACTOR. A free-running phase counter marks one cycle in every FACTOR as the accept cycle. The block raises its accept strobe in that cycle and takes the value on the input bus at the clock edge that ends it. From then on it produces one output word on every clock.

A run-time mode input selects the output behaviour. In zero-fill mode, a captured sample is shown for one cycle and zeros follow for the rest of the period. In hold mode, the sample is repeated for the whole period. The mode is sampled together with the data, so a period always follows a single behaviour.

The upstream source is expected to present one new word per FACTOR cycles and to use the accept strobe as its advance signal. Interpolation filtering after zero fill is left to a following stage.

Top module: `upr_upsampler`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears itself: `out_data` is 0, `out_valid` is 0 and `in_accept` is 0.
- R2: After reset is released, `in_accept` is high in cycles FACTOR-1, 2*FACTOR-1, and so on, counting the first cycle after release as cycle 0. It is low in every other cycle and is never high in two consecutive cycles.
- R3: In the cycle after an accept cycle, `out_data` equals the `in_data` value that was present during the accept cycle.
- R4: When the mode input is 0 (zero fill) during an accept cycle, `out_data` is 0 in the FACTOR-1 cycles after the cycle in which that sample is shown.
- R5: When the mode input is 1 (hold) during an accept cycle, `out_data` keeps the captured value for all FACTOR cycles of the period.
- R6: The mode input is sampled only in accept cycles. A change of mode in any other cycle has no effect on the current period.
- R7: `out_valid` is low from reset until the first capture. It rises in the cycle after the first accept cycle and stays high until the next reset.
- R8: `in_data` has no effect on `out_data` outside accept cycles.
- R9: A reset applied during operation at any phase gives the state of R1. The accept sequence of R2 then restarts from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = zero fill, 1 = hold; sampled in accept cycles |
| in_data | input | DATA_W | Low-rate input sample |
| in_accept | output | 1 | High in the cycle whose closing edge takes `in_data` |
| out_data | output | DATA_W | High-rate output word, registered |
| out_valid | output | 1 | High once a first sample has been captured |

## Verification
The assertions assume that `rst` is held high from the first clock edge, so that the phase counter and the output register start from a known state, and that `mode_sel` and `in_data` are known values at every rising edge. The stimulus keeps to this. It asserts reset at time zero and changes every input only at falling edges. It drives a new data word on every cycle, and not only in accept cycles, so that the hold and zero-fill checks would see any leak from the input. The mode is driven constant in some stretches and pseudo-randomly in others, which also changes it in the middle of a period.

// File: rtl/upr_pkg.sv
package upr_pkg;

  typedef enum logic {
    UPR_ZERO_FILL = 1'b0,
    UPR_HOLD      = 1'b1
  } upr_mode_e;

  // Width of a counter that must reach n-1 (at least one bit).
  function automatic int upr_cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/upr_phase_ctr.sv
module upr_phase_ctr #(
  parameter int FACTOR = 5
) (
  input  logic clk,
  input  logic rst,
  output logic take
);
  localparam int CNT_W = upr_pkg::upr_cnt_width(FACTOR);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FACTOR - 1);
  localparam bit   POW2 = (FACTOR == (1 << CNT_W));

  logic [CNT_W-1:0] phase;

  generate
    if (POW2) begin : g_wrap_free
      // A power-of-two factor wraps naturally, so no compare is needed.
      always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
      end
    end else begin : g_wrap_cmp
      always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end
    end
  endgenerate

  assign take = (phase == LAST) && !rst;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

endmodule

// File: rtl/upr_mode_latch.sv
module upr_mode_latch (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  upr_pkg::upr_mode_e mode_in,
  output upr_pkg::upr_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (rst)       mode_q <= upr_pkg::UPR_ZERO_FILL;
    else if (take) mode_q <= mode_in;
  end

  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(mode_q));

endmodule

// File: rtl/upr_out_stage.sv
module upr_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  upr_pkg::upr_mode_e mode_q,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout,
  output logic               valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else if (take) begin
      dout  <= din;
      valid <= 1'b1;
    end else if (mode_q == upr_pkg::UPR_ZERO_FILL) begin
      dout  <= '0;
    end
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> dout == $past(din));

  // R4
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !$past(take) && mode_q == upr_pkg::UPR_ZERO_FILL) |-> dout == '0);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!take && mode_q == upr_pkg::UPR_HOLD) |=> $stable(dout));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dout == '0 && !valid));

endmodule

// File: rtl/upr_upsampler.sv
module upr_upsampler #(
  parameter int DATA_W = 16,
  parameter int FACTOR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_accept,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  logic               take;
  upr_pkg::upr_mode_e mode_q;
  upr_pkg::upr_mode_e mode_in;

  assign mode_in = upr_pkg::upr_mode_e'(mode_sel);

  upr_phase_ctr #(.FACTOR(FACTOR)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .take (take)
  );

  upr_mode_latch u_mode (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .mode_in (mode_in),
    .mode_q  (mode_q)
  );

  upr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .mode_q(mode_q),
    .din   (in_data),
    .dout  (out_data),
    .valid (out_valid)
  );

  assign in_accept = take;

  // R1
  no_accept_in_reset_chk: assert property (@(posedge clk)
    rst |-> !in_accept);

endmodule

// File: tb/sim_upr_upsampler.sv
`timescale 1ns/1ps
module sim_upr_upsampler;
  localparam int DW = 8;
  localparam int N  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_sel = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_accept;
  logic [DW-1:0] out_data;
  logic          out_valid;

  int checks = 0;
  int fails  = 0;

  // Bench model state, updated from the requirements alone.
  int        c = 0;
  bit        captured = 0;
  bit        exp_mode = 0;
  bit        mid_change = 0;
  int        exp_sample = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;  // 200 MHz

  upr_upsampler #(.DATA_W(DW), .FACTOR(N)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_data(in_data),
    .in_accept(in_accept), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, c, act, exp);
    end
  endtask

  // R1 / R9: outputs while reset is held.
  task automatic reset_cycles(input int n, input string tag);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk({tag, " out_data"},  32'(out_data),  0);
      chk({tag, " out_valid"}, 32'(out_valid), 0);
      chk({tag, " in_accept"}, 32'(in_accept), 0);
    end
    rst = 1'b0;
    c = 0; captured = 0; exp_mode = 0; mid_change = 0;
  endtask

  // mode_kind: 0 zero fill, 1 hold, 2 pseudo-random every cycle
  task automatic run(input int ncyc, input int mode_kind, input int seed);
    for (int i = 0; i < ncyc; i++) begin
      int  ph;
      int  exp_d;
      bit  acc;
      string tg;
      #1;
      ph  = c % N;
      acc = (ph == N - 1);
      // R2: accept position from the cycle count
      chk("R2 in_accept", 32'(in_accept), 32'(acc));
      // R7: valid once a sample was taken
      chk("R7 out_valid", 32'(out_valid), 32'(captured));
      if (!captured)          begin exp_d = 0;          tg = "R7 out_data"; end
      else if (ph == 0)       begin exp_d = exp_sample; tg = "R3 out_data"; end
      else if (exp_mode)      begin exp_d = exp_sample; tg = mid_change ? "R6 out_data" : "R5 R8 out_data"; end
      else                    begin exp_d = 0;          tg = mid_change ? "R6 out_data" : "R4 R8 out_data"; end
      chk(tg, 32'(out_data), 32'(exp_d));
      // Drive this cycle's inputs.
      in_data = DW'(c * 53 + seed * 11 + 7);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode_kind)
        0:       mode_sel = 1'b0;
        1:       mode_sel = 1'b1;
        default: mode_sel = lfsr[0];
      endcase
      if (acc) begin
        exp_sample = int'(in_data);
        exp_mode   = mode_sel;
        captured   = 1;
        mid_change = 0;
      end else if (captured && mode_sel != exp_mode) begin
        mid_change = 1;
      end
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    reset_cycles(3, "R1");
    run(6 * N, 0, 1);          // zero fill throughout
    run(6 * N, 1, 2);          // hold throughout
    run(30 * N, 2, 3);         // mode flips, also inside periods
    @(negedge clk); c++;       // keep phases consistent: skip check, no input change
    // The skipped cycle had the same inputs, so handle it in the model.
    if (c % N == 0) begin
      exp_sample = int'(in_data); exp_mode = mode_sel; captured = 1; mid_change = 0;
    end
    run(2 * N + 2, 1, 4);
    reset_cycles(2, "R9");     // reset at an arbitrary phase
    run(4 * N, 0, 5);
    reset_cycles(1, "R9");
    run(4 * N, 2, 6);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule